// File: doc/BRIEF.md
# Per-Byte Variable Funnel Shifter

This unit takes a 128-bit data vector and a 128-bit control vector and treats each as sixteen byte lanes. Every result lane is its own data byte shifted by its own 3-bit amount. The vacated bits are not zero-filled. They are filled from the adjacent data byte, so each lane is an 8-bit window slid across a 16-bit pair of neighbouring bytes.

A mode input picks the direction. Shifting left pulls bits in from the next-higher-numbered byte. Shifting right pulls bits in from the next-lower-numbered byte. At the outer end of the vector a zero byte stands in for the missing neighbour.

A request is presented with an input strobe. The result appears in a register one clock later, together with an output valid flag. A vector datapath places it between operand fetch and writeback.

Top module: `vbyte_funnel`

## Requirements
- R1: Byte lane 0 occupies bus bits [127:120] and lane 15 occupies bits [7:0]. Inside a lane, the lane's first bit is the most significant bit.
- R2: The shift amount of lane i is bits [2:0] (the three least significant bits) of control byte i. Bits [7:3] of each control byte have no effect on the result.
- R3: With `mode_right`=0 (left), result lane i is the upper 8 bits of the 16-bit value {data lane i, data lane i+1} shifted left by the lane's amount. Data lane 16 is taken as zero.
- R4: With `mode_right`=1 (right), result lane i is the lower 8 bits of the 16-bit value {data lane i-1, data lane i} shifted right by the lane's amount. Data lane -1 is taken as zero.
- R5: A lane whose amount is 0 returns its own data byte unchanged in either mode.
- R6: In left mode, the low `amt` bits of lane 15 are zero. In right mode, the high `amt` bits of lane 0 are zero.
- R7: Lanes are independent. Each lane uses only its own amount, even when every lane carries a different amount.
- R8: A request sampled with `in_valid`=1 on a rising edge is in `result` with `out_valid`=1 after that edge. `out_valid` is 0 after an edge where `in_valid` was 0.
- R9: `result` keeps its value across edges where `in_valid` is 0, whatever the other inputs do.
- R10: With `rst`=1 at a rising edge, `out_valid` and `result` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode_right | input | 1 | 0 = shift left, 1 = shift right |
| data_in | input | 128 | Data vector, lane 0 in the top byte |
| ctrl_in | input | 128 | Per-lane shift amounts in bits [2:0] of each byte |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Shifted vector |

## Verification
Uniform amounts 0 through 7 are swept in both modes over all-ones, alternating and random data. All-ones data exposes any zero-fill that should have been a neighbour fill. Alternating data exposes an off-by-one in the amount. Distinct per-lane amounts separate lane crosstalk from a shared barrel shift. Control bytes with garbage in their upper five bits show that only the low three bits steer the lane. Explicit checks on the first and last lane catch a wrong boundary fill. Idle cycles with changing inputs, and a reset in the middle of the run, cover the register behaviour.

// File: rtl/vbyte_funnel_pkg.sv
package vbyte_funnel_pkg;
    localparam int LANES  = 16;
    localparam int LANE_W = 8;
    localparam int VEC_W  = LANES * LANE_W;
    localparam int AMT_W  = $clog2(LANE_W);

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shdir_e;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        shdir_e dir;
        vec_t   data;
        vec_t   ctrl;
    } req_t;

    // Lane index 0 sits in the most significant byte of the bus.
    function automatic lane_t get_lane(vec_t v, int idx);
        return v[VEC_W-1-idx*LANE_W -: LANE_W];
    endfunction
endpackage

// File: rtl/vbyte_nbr.sv
module vbyte_nbr
    import vbyte_funnel_pkg::*;
(
    input  shdir_e dir,
    input  vec_t   data,
    output vec_t   nbr
);
    // For each lane, the byte that feeds its vacated bits: the following
    // lane when shifting left, the preceding lane when shifting right.
    always_comb begin
        if (dir == DIR_LEFT)
            nbr = {data[VEC_W-LANE_W-1:0], {LANE_W{1'b0}}};
        else
            nbr = {{LANE_W{1'b0}}, data[VEC_W-1:LANE_W]};
    end
endmodule

// File: rtl/vbyte_lane.sv
module vbyte_lane
    import vbyte_funnel_pkg::*;
(
    input  shdir_e dir,
    input  lane_t  own,
    input  lane_t  nbr,
    input  lane_t  ctrl,
    output lane_t  res
);
    logic [AMT_W-1:0]    amt;
    logic [2*LANE_W-1:0] pair;
    logic [2*LANE_W-1:0] moved;

    assign amt = AMT_W'(ctrl);

    always_comb begin
        if (dir == DIR_LEFT) begin
            pair  = {own, nbr};
            moved = pair << amt;
            res   = moved[2*LANE_W-1:LANE_W];
        end else begin
            pair  = {nbr, own};
            moved = pair >> amt;
            res   = moved[LANE_W-1:0];
        end
    end

    // R5: zero amount passes the lane through
    always_comb begin
        if (amt == '0)
            a_r5_zero_amount_identity: assert (res == own);
    end
endmodule

// File: rtl/vbyte_funnel.sv
module vbyte_funnel
    import vbyte_funnel_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         mode_right,
    input  logic [127:0] data_in,
    input  logic [127:0] ctrl_in,
    output logic         out_valid,
    output logic [127:0] result
);
    req_t req;
    vec_t nbr_vec;
    vec_t comb_res;
    vec_t res_q;
    logic vld_q;

    assign req.dir  = shdir_e'(mode_right);
    assign req.data = data_in;
    assign req.ctrl = ctrl_in;

    vbyte_nbr u_nbr (
        .dir  (req.dir),
        .data (req.data),
        .nbr  (nbr_vec)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vbyte_lane u_lane (
            .dir  (req.dir),
            .own  (get_lane(req.data, g)),
            .nbr  (get_lane(nbr_vec, g)),
            .ctrl (get_lane(req.ctrl, g)),
            .res  (comb_res[VEC_W-1-g*LANE_W -: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= comb_res;
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;

    // R8: a strobe yields a valid result on the next cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8: no strobe, no valid
    a_r8_idle_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9: result held while idle
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R6: last lane low bits vacated in left mode
    a_r6_left_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_right && ctrl_in[2:0] == 3'd7) |=> (result[6:0] == 7'd0));
    // R6: first lane high bits vacated in right mode
    a_r6_right_head_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_right && ctrl_in[122:120] == 3'd7) |=> (result[127:121] == 7'd0));
endmodule

// File: tb/vbyte_funnel_test.sv
module vbyte_funnel_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         mode_right;
    logic [127:0] data_in;
    logic [127:0] ctrl_in;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    vbyte_funnel uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_right(mode_right),
        .data_in(data_in), .ctrl_in(ctrl_in), .out_valid(out_valid), .result(result)
    );

    // Bit-by-bit model: byte k at bits [127-8k -: 8], bit 0 = MSB.
    function automatic logic getbit(logic [127:0] d, int byte_i, int bit_i);
        if (byte_i < 0 || byte_i > 15) return 1'b0;
        return d[127 - 8*byte_i - bit_i];
    endfunction

    function automatic logic [127:0] model(logic [127:0] d, logic [127:0] c, logic right);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int sb = int'(c[120 - 8*i +: 3]);
            for (int j = 0; j < 8; j++) begin
                int p;
                logic b;
                if (!right) begin
                    p = sb + j;                       // left: neighbour is i+1
                    b = (p < 8) ? getbit(d, i, p) : getbit(d, i + 1, p - 8);
                end else begin
                    p = j - sb;                       // right: neighbour is i-1
                    b = (p >= 0) ? getbit(d, i, p) : getbit(d, i - 1, p + 8);
                end
                r[127 - 8*i - j] = b;
            end
        end
        return r;
    endfunction

    function automatic logic [127:0] uniform(int amt, logic [4:0] junk);
        logic [127:0] c;
        for (int i = 0; i < 16; i++) c[127 - 8*i -: 8] = {junk, 3'(amt)};
        return c;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(string tag, logic right, logic [127:0] d, logic [127:0] c);
        @(negedge clk);
        in_valid = 1'b1; mode_right = right; data_in = d; ctrl_in = c;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        check(tag, result, model(d, c, right));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] pats [3];
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0; mode_right = 1'b0; data_in = '0; ctrl_in = '0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {127'd0, out_valid}, 128'd0);
        check("R10 reset result", result, '0);
        rst = 1'b0;

        pats[0] = '1;
        pats[1] = {8{16'hA55A}};
        pats[2] = rnd128();
        // R3 R4 R5: uniform amounts in every lane, both modes
        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 2; m++)
                for (int a = 0; a < 8; a++)
                    issue(m ? "R4 uniform" : "R3 uniform", m[0], pats[p], uniform(a, 5'd0));

        // R5: identity at amount 0
        issue("R5 identity left", 1'b0, pats[2], uniform(0, 5'd0));
        check("R5 left equals data", result, pats[2]);
        issue("R5 identity right", 1'b1, pats[2], uniform(0, 5'd0));
        check("R5 right equals data", result, pats[2]);

        // R6: boundary lanes at amount 7 with all-ones data
        issue("R6 left", 1'b0, '1, uniform(7, 5'd0));
        check("R6 lane15 low bits", {120'd0, result[7:0]}, 128'h80);
        issue("R6 right", 1'b1, '1, uniform(7, 5'd0));
        check("R6 lane0 high bits", {120'd0, result[127:120]}, 128'h01);

        // R1: single marker bit at the top of lane 0, left by 0 / right by 1
        issue("R1 order left", 1'b0, {1'b1, 127'd0}, '0);
        check("R1 top bit", result, {1'b1, 127'd0});
        issue("R1 order right", 1'b1, {1'b1, 127'd0}, uniform(1, 5'd0));
        check("R1 bit moves to lane0 bit1", result, {2'b01, 126'd0});

        // R2: upper control bits are garbage
        for (int a = 0; a < 8; a++) begin
            logic [127:0] d = rnd128();
            issue("R2 junk ctrl", a[0], d, uniform(a, 5'h1F));
            check("R2 same as clean ctrl", result, model(d, uniform(a, 5'd0), a[0]));
        end

        // R7: distinct per-lane amounts
        for (int k = 0; k < 40; k++)
            issue((k % 2) ? "R7 per-lane right" : "R7 per-lane left", k[0], rnd128(), rnd128());

        // R9: idle cycles with changing inputs
        held = result;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            data_in = rnd128(); ctrl_in = rnd128(); mode_right = ~mode_right;
            @(negedge clk);
            check("R9 result held", result, held);
            check("R8 idle no valid", {127'd0, out_valid}, 128'd0);
        end

        // R10: reset mid-run
        issue("R10 pre", 1'b0, '1, '0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 result cleared", result, '0);
        check("R10 valid cleared", {127'd0, out_valid}, 128'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule